// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block sends a stereo pair of 16-bit audio samples as a continuous serial stream. It produces a bit clock, a word strobe that marks the channel, and a data line. Software writes a left sample and a right sample into two write-only holding registers. It sets the bit rate with an 8-bit divider and picks, through a mode register, which points in the frame raise an interrupt. The interrupt tells the processor when to supply the next samples.

A frame is 64 bit times: 32 for the left channel (strobe low), then 32 for the right channel (strobe high). In each channel slot the 16-bit sample goes out MSB first, starting one bit time after the strobe changes. Zeros fill the rest of the slot. Each holding register is copied into the output shifter at the start of its channel slot. A write that arrives while a word is being sent therefore only affects the next frame. Writing the divider restarts the frame timing from bit 0.

Top module: `stereo_serial_tx`

## Requirements
- R1: After reset the divider holds 8, the mode and both sample registers hold 0, and sclk_o, ws_o, sd_o, irq_o and status_o are all 0.
- R2: While running, one bit time lasts divider+1 clock cycles and a frame lasts 64 bit times. sclk_o is high in those cycles of a bit time whose in-bit count exceeds floor(divider/2).
- R3: ws_o is low during bits 0..31 (left) and high during bits 32..63 (right) when mode bit 2 is set. It stays low when mode bit 2 is clear.
- R4: sd_o carries sample bit 15 in slot bit 1, down to sample bit 0 in slot bit 16, for each channel. It is 0 in slot bits 0 and 17..31.
- R5: The left sample is captured at the start of bit 0 and the right sample at the start of bit 32. A later write to a sample register changes only the following frame.
- R6: irq_o is a one-cycle pulse in the first cycle of a bit time. It fires at bit 32 when mode bit 3 is set, at bit 0 (after bit 63) when mode bit 4 is set, and at bits 1 and 33 when mode bit 5 is set.
- R7: status_o[0] equals ws_o and status_o[1] is 1 while the right channel (bits 32..63) is active.
- R8: With mode bit 0 clear the timing is held at bit 0, count 0, and sclk_o, ws_o, sd_o and irq_o stay 0.
- R9: A divider write restarts the timing at bit 0, count 0, from the next cycle, without raising an interrupt.
- R10: Write address 0 loads the right sample, 1 the left sample, 2 the divider (wr_data[7:0]) and 3 the mode (wr_data[5:0]). Each write takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 right, 1 left, 2 divider, 3 mode) |
| wr_data | input | 16 | Write data |
| sclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word strobe (low left, high right) |
| sd_o | output | 1 | Serial data |
| irq_o | output | 1 | Interrupt pulse |
| status_o | output | 2 | {active channel, strobe level} |

## Verification
The bench changes a sample register partway through the slot that is sending it. A shifter that was not double-buffered would emit a mixed word there. It switches the divider to 0, where bit times are a single cycle and the fall and MSB interrupts land in back-to-back cycles. It writes the divider in the middle of a frame; a design that did not restart would keep its old bit position, and one that did restart might raise a false interrupt. It counts interrupts over exact frame windows for each mode bit alone, which exposes a swapped edge selection or a missing second MSB event.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  typedef enum logic [1:0] {
    ADDR_RIGHT = 2'd0,
    ADDR_LEFT  = 2'd1,
    ADDR_DIV   = 2'd2,
    ADDR_MODE  = 2'd3
  } sstx_addr_e;

  localparam int MODE_W        = 6;
  localparam int MODE_CLK_EN   = 0;
  localparam int MODE_WS_EN    = 2;
  localparam int MODE_IRQ_RISE = 3;
  localparam int MODE_IRQ_FALL = 4;
  localparam int MODE_IRQ_MSB  = 5;
endpackage

// File: rtl/sstx_regs.sv
module sstx_regs
  import sstx_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic [SAMPLE_W-1:0] right_q,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [DIV_W-1:0]    div_q,
  output logic [MODE_W-1:0]   mode_q,
  output logic                restart_o
);
  logic [SAMPLE_W-1:0] right_d, left_d;
  logic [DIV_W-1:0]    div_d;
  logic [MODE_W-1:0]   mode_d;

  assign restart_o = wr_en && (wr_addr == ADDR_DIV);

  always_comb begin
    right_d = right_q;
    left_d  = left_q;
    div_d   = div_q;
    mode_d  = mode_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_RIGHT: right_d = wr_data;
        ADDR_LEFT:  left_d  = wr_data;
        ADDR_DIV:   div_d   = wr_data[DIV_W-1:0];
        default:    mode_d  = wr_data[MODE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      right_q <= '0;
      left_q  <= '0;
      div_q   <= DIV_W'(DIV_RESET);
      mode_q  <= '0;
    end else begin
      right_q <= right_d;
      left_q  <= left_d;
      div_q   <= div_d;
      mode_q  <= mode_d;
    end
  end
endmodule

// File: rtl/sstx_bitclk.sv
module sstx_bitclk #(
  parameter int DIV_W = 8,
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic [POS_W-1:0] pos_o,
  output logic             tick_o,
  output logic             sclk_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [POS_W-1:0] pos_q, pos_d;

  assign tick_o = run_i && !restart_i && (cnt_q == div_i);
  assign sclk_o = run_i && (cnt_q > (div_i >> 1));
  assign cnt_o  = cnt_q;
  assign pos_o  = pos_q;

  always_comb begin
    cnt_d = cnt_q;
    pos_d = pos_q;
    if (restart_i || !run_i) begin
      cnt_d = '0;
      pos_d = '0;
    end else if (tick_o) begin
      cnt_d = '0;
      pos_d = pos_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pos_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pos_q <= pos_d;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_i);
  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (pos_q == POS_W'($past(pos_q) + 1'b1)));
  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i || !run_i) |=> (cnt_q == '0 && pos_q == '0));
endmodule

// File: rtl/sstx_serializer.sv
module sstx_serializer
  import sstx_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_BITS = 32,
  parameter int POS_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                restart_i,
  input  logic                tick_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sd_o,
  output logic                ws_o,
  output logic                chan_o,
  output logic                irq_o
);
  localparam int SLOT_W = POS_W - 1;
  localparam logic [POS_W-1:0]  POS_RIGHT = POS_W'(SLOT_BITS);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] shift_q, shift_d;
  logic                irq_q, irq_d;
  logic [POS_W-1:0]    pos_nxt;
  logic [SLOT_W-1:0]   slot, slot_nxt;
  logic                in_win;

  assign pos_nxt  = pos_i + 1'b1;
  assign slot     = pos_i[SLOT_W-1:0];
  assign slot_nxt = pos_nxt[SLOT_W-1:0];
  assign in_win   = (slot != '0) && (slot <= SLOT_LAST);
  assign chan_o   = pos_i[POS_W-1];
  assign ws_o     = mode_i[MODE_WS_EN] && chan_o;
  assign sd_o     = in_win && shift_q[SAMPLE_W-1];
  assign irq_o    = irq_q;

  always_comb begin
    shift_d = shift_q;
    irq_d   = 1'b0;
    if (restart_i || !run_i) begin
      shift_d = left_i;
    end else if (tick_i) begin
      if (pos_nxt == '0)            shift_d = left_i;
      else if (pos_nxt == POS_RIGHT) shift_d = right_i;
      else if (in_win)              shift_d = shift_q << 1;
      irq_d = (mode_i[MODE_IRQ_RISE] && pos_nxt == POS_RIGHT) ||
              (mode_i[MODE_IRQ_FALL] && pos_nxt == '0) ||
              (mode_i[MODE_IRQ_MSB]  && slot_nxt == SLOT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      irq_q   <= irq_d;
    end
  end

  // R6
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(tick_i));
endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import sstx_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 8,
  parameter int SLOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic                sclk_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                irq_o,
  output logic [1:0]          status_o
);
  localparam int POS_W = $clog2(SLOT_BITS) + 1;

  logic [SAMPLE_W-1:0] right_q, left_q;
  logic [DIV_W-1:0]    div_q, cnt;
  logic [MODE_W-1:0]   mode_q;
  logic [POS_W-1:0]    pos;
  logic                restart, tick, run, chan;

  assign run = mode_q[MODE_CLK_EN];

  sstx_regs #(.SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .right_q(right_q), .left_q(left_q), .div_q(div_q), .mode_q(mode_q),
    .restart_o(restart)
  );

  sstx_bitclk #(.DIV_W(DIV_W), .POS_W(POS_W)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart), .div_i(div_q),
    .cnt_o(cnt), .pos_o(pos), .tick_o(tick), .sclk_o(sclk_o)
  );

  sstx_serializer #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart), .tick_i(tick),
    .pos_i(pos), .mode_i(mode_q), .left_i(left_q), .right_i(right_q),
    .sd_o(sd_o), .ws_o(ws_o), .chan_o(chan), .irq_o(irq_o)
  );

  assign status_o = {chan, ws_o};

  // R3
  ws_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ws_o |-> status_o[1]);
  // R6
  irq_bit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt == '0));
  // R8
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq_o);
endmodule

// File: tb/stereo_serial_tx_bench.sv
module stereo_serial_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        sclk_o, ws_o, sd_o, irq_o;
  logic [1:0]  status_o;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  int irq_total = 0;

  int m_cnt, m_pos, m_div, m_mode, m_right, m_left, m_word;
  bit m_irq;

  always #2.5 clk = ~clk;

  stereo_serial_tx u_stereo_serial_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o), .irq_o(irq_o), .status_o(status_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pos = 0; m_div = 8; m_mode = 0;
      m_right = 0; m_left = 0; m_word = 0; m_irq = 0;
    end else begin
      if ((wr_en && wr_addr == 2'd2) || m_mode[0] == 1'b0) begin
        m_cnt = 0; m_pos = 0; m_word = m_left; m_irq = 0;
      end else if (m_cnt == m_div) begin
        m_cnt = 0;
        m_pos = (m_pos + 1) % 64;
        m_irq = (m_pos == 32 && m_mode[3]) || (m_pos == 0 && m_mode[4]) ||
                (m_pos % 32 == 1 && m_mode[5]);
        if (m_pos == 0) m_word = m_left;
        else if (m_pos == 32) m_word = m_right;
      end else begin
        m_cnt++;
        m_irq = 0;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_right = wr_data;
          2'd1: m_left  = wr_data;
          2'd2: m_div   = wr_data & 16'hFF;
          default: m_mode = wr_data & 16'h3F;
        endcase
      end
    end
    if (irq_o) irq_total++;
  end

  // Compare against the model away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      int idx;
      bit e_sclk, e_ws, e_sd;
      idx    = m_pos % 32;
      e_sclk = m_mode[0] && (m_cnt > m_div / 2);
      e_ws   = m_mode[2] && (m_pos >= 32);
      e_sd   = (idx >= 1 && idx <= 16) ? m_word[16 - idx] : 1'b0;
      check(sclk_o == e_sclk, "R2 sclk", sclk_o, e_sclk);
      check(ws_o == e_ws, "R3 ws", ws_o, e_ws);
      check(sd_o == e_sd, "R4/R5 sd", sd_o, e_sd);
      check(irq_o == m_irq, "R6 irq", irq_o, m_irq);
      check(status_o == {m_pos >= 32, e_ws}, "R7 status", status_o, {m_pos >= 32, e_ws});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_irq(input int win, input int exp, input string tag);
    int start;
    @(negedge clk);
    start = irq_total;
    repeat (win) @(negedge clk);
    check(irq_total - start == exp, tag, irq_total - start, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(sclk_o == 0 && ws_o == 0 && sd_o == 0, "R1 lines", {sclk_o, ws_o, sd_o}, 0);
    check(irq_o == 0 && status_o == 0, "R1 irq/status", {irq_o, status_o}, 0);
    cmp_en = 1'b1;
    // R10: register map, R1 default divider 8
    wr(2'd0, 16'hA5C3);
    wr(2'd1, 16'h1234);
    wr(2'd3, 16'h0005);
    repeat (1200) @(negedge clk);
    // R6: all interrupt sources, one frame = 64*9 cycles
    wr(2'd3, 16'h003D);
    repeat (10) @(negedge clk);
    count_irq(576, 4, "R6 all events div8");
    // R5: sample write in the middle of a slot
    repeat (20) @(negedge clk);
    wr(2'd1, 16'hF00F);
    wr(2'd0, 16'h0FF0);
    repeat (700) @(negedge clk);
    // R9: divider 0, single-cycle bits
    wr(2'd2, 16'h0000);
    repeat (37) @(negedge clk);
    count_irq(64, 4, "R6 all events div0");
    wr(2'd2, 16'h0003);
    wr(2'd3, 16'h0009);
    count_irq(256, 1, "R6 rise only");
    wr(2'd0, 16'h8001);
    wr(2'd3, 16'h0011);
    count_irq(256, 1, "R6 fall only");
    wr(2'd3, 16'h0021);
    count_irq(256, 2, "R6 msb only");
    // R3: strobe disabled
    wr(2'd3, 16'h0001);
    repeat (300) @(negedge clk);
    // R9: restart mid-frame
    wr(2'd3, 16'h003D);
    repeat (150) @(negedge clk);
    wr(2'd2, 16'h0005);
    repeat (500) @(negedge clk);
    // R8: stopped
    wr(2'd3, 16'h0000);
    repeat (100) @(negedge clk);
    check(sclk_o == 0 && ws_o == 0 && sd_o == 0 && irq_o == 0, "R8 stopped",
          {sclk_o, ws_o, sd_o, irq_o}, 0);
    wr(2'd3, 16'h003D);
    repeat (800) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule